// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Logic

This block keeps the completion and error status of one DMA channel in a 32-bit register that software can read. The transfer engine reports single-cycle events: the transfer finished, a source access failed, a destination access failed, or the setup was wrong. The block turns these events into sticky flags. It raises a completion interrupt request and a fault interrupt request while the matching flag is set and its enable input is high.

Start requests from the engine side pass through the block. A start is accepted only when neither completion flag is pending. An accepted start is passed on as a one-cycle `start_go` and marks the channel busy. A start that arrives while a flag is pending is refused: it is recorded as a setup error and the fault flag is raised.

Software clears a flag by writing 0 to its bit. Writing 1 to a flag leaves it unchanged. Clearing the fault flag also wipes the three error-cause bits.

Top module: `dma_chan_status`

## Requirements
- R1: After reset every bit of `rd_data` is 0, and `irq_done`, `irq_fault` and `start_go` are 0.
- R2: `rd_data` places busy at bit 31, done at bit 23, fault at bit 22, source error at bit 20, destination error at bit 19 and setup error at bit 18. All other bits, including reserved bit 21 and bits 2:0, always read 0.
- R3: A cycle with `ev_done` high sets done (bit 23) at the next edge. A write with `wr_data[23]`=0 clears done. A write with `wr_data[23]`=1 leaves done unchanged.
- R4: Fault (bit 22) is set at the next edge by any error event or by a refused start. A write with `wr_data[22]`=0 clears fault. A write with `wr_data[22]`=1 leaves fault unchanged.
- R5: `irq_done` is high exactly while done is 1 and `ie_done` is 1. It drops in the same cycle that done is cleared.
- R6: `irq_fault` is high exactly while fault is 1 and `ie_fault` is 1. It drops in the same cycle that fault is cleared.
- R7: When a write clears fault, bits 20, 19 and 18 are cleared at the same edge.
- R8: `ev_src_err` sets bit 20, `ev_dst_err` sets bit 19 and `ev_cfg_err` sets bit 18. Each of these events also sets fault and clears busy (bit 31).
- R9: A `start_req` while done or fault is 1 gives `start_go`=0. At the next edge it sets bit 18 and fault.
- R10: A `start_req` while done and fault are both 0 drives `start_go`=1 in the same cycle and sets busy at the next edge. `ev_done` or any error event clears busy, unless an accepted start arrives in the same cycle, in which case the start wins.
- R11: When a set event and a clearing write hit the same flag in one cycle, the flag ends up 1. In that case the cause bits are kept, and any new cause bits are added to them.
- R12: Writes never change bits 31, 20, 19 or 18, except through the clearing of fault described in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software register write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Status register read value |
| ie_done | input | 1 | Completion interrupt enable |
| ie_fault | input | 1 | Fault interrupt enable |
| start_req | input | 1 | Start request for the channel |
| start_go | output | 1 | Accepted start passed to the engine |
| ev_done | input | 1 | Engine pulse: transfer finished normally |
| ev_src_err | input | 1 | Engine pulse: source access bus error |
| ev_dst_err | input | 1 | Engine pulse: destination access bus error |
| ev_cfg_err | input | 1 | Engine pulse: setup error |
| irq_done | output | 1 | Completion interrupt request |
| irq_fault | output | 1 | Fault interrupt request |

## Verification
The block has no parameters, so the bench builds it exactly as it ships. The bench has ten single-cycle inputs: the write strobe, the two flag bits of the write data, the start request, the four engine events and the two enables. It applies every one of their 1024 combinations twice, in two different orders. Consecutive vectors reach each combination from many different flag states. This covers the collisions between a set event and a clearing write, and between a start and an engine event. A bench-side model, written from the requirements, predicts every register bit and output after each edge.

// File: rtl/dma_chan_status.sv
module dma_chan_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        ie_done,
  input  logic        ie_fault,
  input  logic        start_req,
  output logic        start_go,
  input  logic        ev_done,
  input  logic        ev_src_err,
  input  logic        ev_dst_err,
  input  logic        ev_cfg_err,
  output logic        irq_done,
  output logic        irq_fault
);

  localparam int BUSY_B = 31;
  localparam int DONE_B = 23;
  localparam int FLT_B  = 22;

  logic       busy, done, fault;
  logic [2:0] cause;

  logic       refused, any_err, fault_set, fault_clr, done_clr;
  logic [2:0] new_cause;

  assign refused   = start_req & (done | fault);
  assign start_go  = start_req & ~done & ~fault;
  assign new_cause = {ev_src_err, ev_dst_err, ev_cfg_err | refused};
  assign any_err   = |new_cause;
  assign fault_set = any_err;
  assign fault_clr = wr_en & ~wr_data[FLT_B] & ~fault_set;
  assign done_clr  = wr_en & ~wr_data[DONE_B] & ~ev_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      fault <= 1'b0;
      cause <= 3'b000;
    end else begin
      busy <= start_go | (busy & ~(ev_done | any_err));

      if (ev_done)       done <= 1'b1;
      else if (done_clr) done <= 1'b0;

      if (fault_set)      fault <= 1'b1;
      else if (fault_clr) fault <= 1'b0;

      if (fault_clr) cause <= 3'b000;
      else           cause <= cause | new_cause;
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[BUSY_B] = busy;
    rd_data[DONE_B] = done;
    rd_data[FLT_B]  = fault;
    rd_data[20:18]  = cause;
  end

  assign irq_done  = done & ie_done;
  assign irq_fault = fault & ie_fault;

endmodule

module dma_chan_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        start_req,
  input logic        start_go,
  input logic        ev_done,
  input logic        irq_done,
  input logic        irq_fault
);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[21] == 1'b0) && (rd_data[17:0] == '0) && (rd_data[30:24] == '0));

  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[23] && !ev_done) |=> $stable(rd_data[23]));

  // R11
  done_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> rd_data[23]);

  // R5
  irq_done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[23]) |-> !irq_done);

  // R6
  irq_fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[22]) |-> !irq_fault);

  // R7
  cause_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[22]) |-> (rd_data[20:18] == 3'b000));

  // R9
  refuse_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && (rd_data[23] || rd_data[22])) |-> !start_go);

  // R9
  refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && (rd_data[23] || rd_data[22])) |=> (rd_data[22] && rd_data[18]));

  // R10
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> rd_data[31]);

endmodule

bind dma_chan_status dma_chan_status_chk u_chk (.*);

// File: tb/tb_dma_chan_status.sv
`timescale 1ns/1ps
module tb_dma_chan_status;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ie_done = 1'b0, ie_fault = 1'b0;
  logic        start_req = 1'b0;
  logic        start_go;
  logic        ev_done = 1'b0, ev_src_err = 1'b0, ev_dst_err = 1'b0, ev_cfg_err = 1'b0;
  logic        irq_done, irq_fault;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_chan_status dut (.*);

  logic m_busy, m_done, m_fault;
  logic [2:0] m_cause;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_reg();
    logic [31:0] r;
    r = '0;
    r[31] = m_busy; r[23] = m_done; r[22] = m_fault; r[20:18] = m_cause;
    return r;
  endfunction

  task automatic check_state();
    chk("R2 R12 register", rd_data, m_reg());
    chk("R5 irq_done", {31'b0, irq_done}, {31'b0, m_done & ie_done});
    chk("R6 irq_fault", {31'b0, irq_fault}, {31'b0, m_fault & ie_fault});
  endtask

  task automatic apply(input logic [9:0] v);
    logic ok, ref_s, err, fclr, dclr;
    logic [2:0] nc;
    wr_en      = v[0];
    wr_data    = {$urandom} ;
    wr_data[23] = v[1];
    wr_data[22] = v[2];
    start_req  = v[3];
    ev_done    = v[4];
    ev_src_err = v[5];
    ev_dst_err = v[6];
    ev_cfg_err = v[7];
    ie_done    = v[8];
    ie_fault   = v[9];
    #1;
    ok    = start_req & ~m_done & ~m_fault;
    ref_s = start_req & (m_done | m_fault);
    if (ok) chk("R10 start_go", {31'b0, start_go}, 32'd1);
    else    chk("R9 start_go", {31'b0, start_go}, 32'd0);
    check_state();
    nc   = {ev_src_err, ev_dst_err, ev_cfg_err | ref_s};
    err  = |nc;
    fclr = wr_en & ~wr_data[22] & ~err;
    dclr = wr_en & ~wr_data[23] & ~ev_done;
    m_busy  = ok ? 1'b1 : ((ev_done | err) ? 1'b0 : m_busy);
    m_done  = ev_done ? 1'b1 : (dclr ? 1'b0 : m_done);
    m_fault = err ? 1'b1 : (fclr ? 1'b0 : m_fault);
    m_cause = fclr ? 3'b000 : (m_cause | nc);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_busy = 0; m_done = 0; m_fault = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 irqs", {30'b0, irq_done, irq_fault}, 32'h0);
    chk("R1 start_go", {31'b0, start_go}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", rd_data, 32'h0);

    // R10 directed: start, then done clears busy
    apply(10'b0000001000);
    @(negedge clk);
    chk("R10 busy set", rd_data, 32'h8000_0000);
    apply(10'b1100010000);
    @(negedge clk);
    chk("R3 done set", rd_data, 32'h0080_0000);
    chk("R5 irq", {31'b0, irq_done}, 32'd1);
    // R9 refused start
    apply(10'b0000001000);
    @(negedge clk);
    chk("R9 refused", rd_data, 32'h00C4_0000);
    // R7 clear fault only
    apply(10'b0000000011);
    @(negedge clk);
    chk("R7 wipe", rd_data, 32'h0080_0000);

    // R3 R4 R8 R11 R12 exhaustive sweeps
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 1024; i++) begin
        logic [9:0] v;
        v = 10'((i * (pass ? 37 : 613) + 5) % 1024);
        apply(v);
        @(negedge clk);
      end
    end
    ev_done = 0; ev_src_err = 0; ev_dst_err = 0; ev_cfg_err = 0;
    start_req = 0; wr_en = 0;
    #1 check_state();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule